// File: doc/BRIEF.md
# Fractional Capacitor-Array Tuning Controller

This block converts a fine-tuning codeword into on/off controls for a bank of identical unit tuning elements. The codeword has an integer field and a fraction field. The integer field sets how many elements stay enabled. The fraction field feeds a first-order sigma-delta accumulator that steps once per reference-clock tick. On each tick it can switch on one further element, so that this element's average on-time equals the fraction.

New codewords arrive on a valid/ready stream. The block holds one accepted word in a single-entry slot and applies it at the next reference tick. While that slot is full, `cw_ready` is low, and the producer must keep `cw_valid` and `cw_data` steady until it sees a handshake. The slot empties on a tick and `cw_ready` rises in the following cycle. A word is accepted only in a cycle where both `cw_valid` and `cw_ready` are high.

The element-enable output is a registered thermometer code, and it changes only on reference ticks. An optional dither bit can be added to the accumulator's least significant bit.

Top module: `fine_tune_array_ctrl`

## Requirements
- R1: After reset, every element enable is 0, `cw_ready` is 1 and the accumulator is zero. With fraction 8 and no dither, the first tick after reset adds no extra element and the second tick does.
- R2: `cw_ready` is 1 exactly when the holding slot is empty. An accepted word drops `cw_ready` in the next cycle. `cw_ready` stays low until a tick, and it is high again in the cycle after that tick.
- R3: A held word takes effect only at the next tick. Between ticks, `elem_en` does not change. The value computed at a tick appears on `elem_en` right after that clock edge.
- R4: The codeword layout is `cw_data[13:4]` = integer count and `cw_data[3:0]` = fraction. With fraction 0 and dither off, `elem_en[k]` is 1 exactly when k < integer, and bit 0 is element 0.
- R5: On each tick, sum = acc + fraction + dither term. The extra element is on for that tick when sum ≥ 16, and acc becomes sum mod 16. Over 16 ticks starting from acc 0, fraction 7 gives exactly 7 ticks with the extra element on.
- R6: The extra element is the element at index equal to the integer count, so the output stays a thermometer code of (integer + carry) ones.
- R7: With integer 1023 and the carry set, all 1024 elements are on and nothing wraps. With integer 1023 and no carry, element 1023 is off.
- R8: When `dither_en` is 1, `dither_in` is added to the accumulator's least significant bit. When `dither_en` is 0, `dither_in` has no effect on `elem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | A codeword is offered |
| cw_ready | output | 1 | The holding slot is empty and can accept a word |
| cw_data | input | 14 | Codeword: integer in [13:4], fraction in [3:0] |
| ref_tick | input | 1 | One-cycle reference-clock enable that steps the modulator |
| dither_en | input | 1 | Enables the dither term |
| dither_in | input | 1 | Dither bit added to the accumulator LSB |
| elem_en | output | 1024 | Thermometer-coded element enables |

## Verification
The accumulator is the only state that `elem_en` does not show directly. A wrong residue cannot be seen until a later tick moves a carry one tick early or late, which is why the bench compares every clock against a behavioural model over long runs of ticks. A fault in the slot or in the held word shows up at the first tick after the accept, either as a wrong popcount of `elem_en` or as `cw_ready` failing to return high. A fault in the thermometer decoder or in saturation shows up in the same cycle, as bits that break the thermometer shape or as the wrong count at integer 1023.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int DEF_INT_W  = 10;
  localparam int DEF_FRAC_W = 4;

  typedef enum logic {SLOT_EMPTY = 1'b0, SLOT_FULL = 1'b1} slot_state_t;
endpackage

// File: rtl/tune_word_slot.sv
// Single-entry holding slot plus the active codeword register.
module tune_word_slot #(
  parameter int CW_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CW_W-1:0] in_data,
  input  logic            tick,
  output logic [CW_W-1:0] eff_word
);
  import tune_pkg::*;

  slot_state_t     state_q;
  logic [CW_W-1:0] held_q;
  logic [CW_W-1:0] active_q;
  logic            take;

  assign in_ready = (state_q == SLOT_EMPTY);
  assign take     = in_valid && in_ready;
  // Word in force for a tick in this cycle
  assign eff_word = (state_q == SLOT_FULL) ? held_q : active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SLOT_EMPTY;
      held_q   <= '0;
      active_q <= '0;
    end else begin
      if (tick) begin
        active_q <= eff_word;
        if (state_q == SLOT_FULL) state_q <= SLOT_EMPTY;
      end
      if (take) begin
        held_q  <= in_data;
        state_q <= SLOT_FULL;
      end
    end
  end
endmodule

// File: rtl/tune_sdm.sv
// First-order sigma-delta accumulator on the fraction field.
module tune_sdm #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FRAC_W-1:0] frac,
  input  logic              dither_bit,
  output logic              carry
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  assign sum   = SUM_W'(acc_q) + SUM_W'(frac) + SUM_W'(dither_bit);
  assign carry = sum[SUM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/tune_thermo.sv
// Thermometer decoder with registered output, updated on ticks.
module tune_thermo #(
  parameter int INT_W  = 10,
  parameter int N_ELEM = 1 << INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [INT_W-1:0] int_val,
  input  logic             extra,
  output logic [N_ELEM-1:0] elem_en
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  count;
  logic [N_ELEM-1:0] next_en;

  // Count never exceeds N_ELEM, so saturation is natural
  assign count = CNT_W'(int_val) + CNT_W'(extra);

  for (genvar k = 0; k < N_ELEM; k++) begin : g_cell
    assign next_en[k] = (CNT_W'(k) < count);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    elem_en <= '0;
    else if (tick) elem_en <= next_en;
  end
endmodule

// File: rtl/fine_tune_array_ctrl.sv
module fine_tune_array_ctrl #(
  parameter int INT_W  = tune_pkg::DEF_INT_W,
  parameter int FRAC_W = tune_pkg::DEF_FRAC_W,
  localparam int CW_W   = INT_W + FRAC_W,
  localparam int N_ELEM = 1 << INT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_valid,
  output logic              cw_ready,
  input  logic [CW_W-1:0]   cw_data,
  input  logic              ref_tick,
  input  logic              dither_en,
  input  logic              dither_in,
  output logic [N_ELEM-1:0] elem_en
);
  logic [CW_W-1:0] eff_word;
  logic            carry;
  logic            dither_bit;

  assign dither_bit = dither_en & dither_in;

  tune_word_slot #(.CW_W(CW_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(cw_valid), .in_ready(cw_ready),
    .in_data(cw_data), .tick(ref_tick), .eff_word(eff_word)
  );

  tune_sdm #(.FRAC_W(FRAC_W)) u_sdm (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick),
    .frac(eff_word[FRAC_W-1:0]), .dither_bit(dither_bit), .carry(carry)
  );

  tune_thermo #(.INT_W(INT_W), .N_ELEM(N_ELEM)) u_thermo (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick),
    .int_val(eff_word[CW_W-1:FRAC_W]), .extra(carry), .elem_en(elem_en)
  );
endmodule

// File: rtl/tune_ctrl_checker.sv
module tune_ctrl_checker #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cw_valid,
  input logic                      cw_ready,
  input logic                      ref_tick,
  input logic [INT_W+FRAC_W-1:0]   eff_word,
  input logic [(1<<INT_W)-1:0]     elem_en
);
  localparam int N_ELEM = 1 << INT_W;

  int eff_int;
  assign eff_int = int'(eff_word[INT_W+FRAC_W-1:FRAC_W]);

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && cw_ready |=> !cw_ready);

  assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_ready && ref_tick |=> cw_ready);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(elem_en));

  assert_thermo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((elem_en + N_ELEM'(1)) & elem_en) == '0);

  assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> ($countones(elem_en) >= $past(eff_int)) &&
                 ($countones(elem_en) <= $past(eff_int) + 1));
endmodule

bind fine_tune_array_ctrl tune_ctrl_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
  .ref_tick(ref_tick), .eff_word(eff_word), .elem_en(elem_en)
);

// File: tb/fine_tune_array_ctrl_bench.sv
module fine_tune_array_ctrl_bench;
  localparam int INT_W = 10;
  localparam int FRAC_W = 4;
  localparam int CW_W = 14;
  localparam int N = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cw_valid = 1'b0;
  logic [CW_W-1:0] cw_data = '0;
  logic ref_tick = 1'b0;
  logic dither_en = 1'b0;
  logic dither_in = 1'b0;
  logic cw_ready;
  logic [N-1:0] elem_en;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  bit m_pend;
  int m_pword, m_act, m_acc, m_cnt;
  int carry_seen;

  fine_tune_array_ctrl u_fine_tune_array_ctrl (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_data(cw_data), .ref_tick(ref_tick), .dither_en(dither_en),
    .dither_in(dither_in), .elem_en(elem_en)
  );

  always #2 clk = ~clk;

  function automatic logic [N-1:0] thermo(int c);
    logic [N-1:0] v = '0;
    for (int k = 0; k < N; k++) if (k < c) v[k] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " elem_en"}, elem_en === thermo(m_cnt), $countones(elem_en), m_cnt);
    check({tag, " cw_ready"}, cw_ready === !m_pend, int'(cw_ready), int'(!m_pend));
  endtask

  task automatic model_reset();
    m_pend = 0; m_pword = 0; m_act = 0; m_acc = 0; m_cnt = 0;
  endtask

  task automatic step(string tag, bit v, int cw, bit t, bit de, bit di);
    bit acc_ok;
    int eff, sum, c;
    @(negedge clk);
    cw_valid = v; cw_data = CW_W'(cw); ref_tick = t; dither_en = de; dither_in = di;
    @(posedge clk);
    acc_ok = v && !m_pend;
    if (t) begin
      eff = m_pend ? m_pword : m_act;
      m_act = eff;
      sum = m_acc + (eff % 16) + ((de && di) ? 1 : 0);
      c = (sum >= 16) ? 1 : 0;
      carry_seen += c;
      m_acc = sum % 16;
      m_cnt = (eff / 16) + c;
      m_pend = 0;
    end
    if (acc_ok) begin m_pend = 1; m_pword = cw; end
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cw_valid = 0; ref_tick = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    model_reset();
    #0;
    check("R1 reset elem_en zero", elem_en === '0, $countones(elem_en), 0);
    check("R1 reset ready high", cw_ready === 1'b1, int'(cw_ready), 1);
  endtask

  task automatic load_apply(string tag, int cw, bit de, bit di);
    step(tag, 1, cw, 0, de, di);
    step(tag, 0, 0, 1, de, di);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 R9 layout: int 5, frac 0
    load_apply("R4", 5 * 16, 0, 0);
    check("R4 five elements", $countones(elem_en) == 5 && elem_en[4] && !elem_en[5],
          $countones(elem_en), 5);
    // R2 back-pressure and R3 pending not visible
    step("R2", 1, 9 * 16, 0, 0, 0);
    check("R2 ready low after accept", cw_ready === 1'b0, int'(cw_ready), 0);
    step("R3", 1, 3 * 16, 0, 0, 0);
    check("R3 pending not applied", $countones(elem_en) == 5, $countones(elem_en), 5);
    step("R2", 0, 0, 1, 0, 0);
    check("R2 ready back after tick", cw_ready === 1'b1, int'(cw_ready), 1);
    check("R3 applied at tick", $countones(elem_en) == 9, $countones(elem_en), 9);
    // accept and tick in the same cycle with empty slot
    step("R3", 1, 12 * 16, 1, 0, 0);
    check("R3 tick uses active word", $countones(elem_en) == 9, $countones(elem_en), 9);
    step("R3", 0, 0, 1, 0, 0);
    check("R3 new word at next tick", $countones(elem_en) == 12, $countones(elem_en), 12);
    // R5 R6 duty 7/16 on int 2
    do_reset();
    load_apply("R5", 2 * 16 + 7, 0, 0);
    carry_seen = 0;
    for (int i = 0; i < 16; i++) step("R5 R6", 0, 0, 1, 0, 0);
    check("R5 duty 7 of 16", carry_seen == 7, carry_seen, 7);
    // R8 ignored when disabled
    do_reset();
    load_apply("R8", 4 * 16, 0, 1);
    carry_seen = 0;
    for (int i = 0; i < 8; i++) step("R8 off", 0, 0, 1, 0, 1);
    check("R8 dither ignored", carry_seen == 0 && $countones(elem_en) == 4, carry_seen, 0);
    carry_seen = 0;
    for (int i = 0; i < 16; i++) step("R8 on", 0, 0, 1, 1, 1);
    check("R8 dither adds one per 16", carry_seen == 1, carry_seen, 1);
    load_apply("R8", 4 * 16 + 15, 1, 1);
    carry_seen = 0;
    for (int i = 0; i < 8; i++) step("R8 full", 0, 0, 1, 1, 1);
    check("R8 frac15 plus dither always carries", carry_seen == 8, carry_seen, 8);
    // R7 saturation
    do_reset();
    load_apply("R7", 1023 * 16, 0, 0);
    check("R7 no carry leaves top off", elem_en[1023] === 1'b0 && $countones(elem_en) == 1023,
          $countones(elem_en), 1023);
    load_apply("R7", 1023 * 16 + 15, 0, 0);
    step("R7", 0, 0, 1, 0, 0);
    check("R7 all elements on", elem_en === '1, $countones(elem_en), 1024);
    // R1 accumulator cleared by reset
    do_reset();
    load_apply("R1", 8, 0, 0);
    check("R1 first tick no carry", $countones(elem_en) == 0, $countones(elem_en), 0);
    step("R1", 0, 0, 1, 0, 0);
    check("R1 second tick carry", $countones(elem_en) == 1, $countones(elem_en), 1);
    // varied pattern run with per-clock comparison
    for (int i = 0; i < 200; i++)
      step("R5 R3 mix", (i % 7) == 0, (i * 37) % 16384, (i % 3) == 0, (i % 11) < 5, (i % 2) == 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule